// File: doc/BRIEF.md
# Divide-by-96 Clock Divider

This block takes one fast reference clock and makes a slow output at one ninety-sixth of its rate, for example 100 kHz from a 9.6 MHz reference. It also gives a one-cycle pulse once per output period. Every stage runs on the single input clock and advances through synchronous enables. Stage clears and counter reloads happen on clock edges, so the output cannot glitch.

Three structures are available, and one is chosen while reset is held. The skewed chain feeds a divide-by-16 prescaler into a three-bit stage. That stage clears itself when it detects its two upper bits both set. The output is taken from that stage's top bit, so the duty cycle is one third. The balanced chain divides by 8, then by 6, then toggles, which gives an exact 50 % duty. The reload counter is a seven-bit counter that reloads on its end-of-count state. It can count upward (reload 32, end at 127) or downward (reload 95, end at 0). Either way it visits 96 states per period.

The divided output and the pulse are registered. The two selection inputs are captured only while reset is asserted.

Top module: `div96_top`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `div_clk` and `tc_pulse` are 0.
- R2: In every mode, `tc_pulse` is high for exactly one cycle. It first rises on the 96th rising edge after `rst` falls, then every 96 edges after that.
- R3: With `mode_sel` = 2'b00 (skewed chain), after edge n since reset release `div_clk` = 1 exactly when floor(n/16) mod 6 is 4 or 5. That is 64 cycles low, then 32 cycles high.
- R4: With `mode_sel` = 2'b01 (balanced chain), after edge n `div_clk` = floor(n/48) mod 2. That is 48 cycles low, then 48 cycles high.
- R5: With `mode_sel` = 2'b10 or 2'b11 and `count_down` = 0, after edge n `div_clk` = 1 exactly when n mod 96 >= 32. The counter runs from 32 up to 127 and then reloads.
- R6: With `mode_sel` = 2'b10 or 2'b11 and `count_down` = 1, `div_clk` follows the same waveform as in R5. The counter runs from 95 down to 0 and then reloads.
- R7: `mode_sel` and `count_down` are captured only while `rst` is high. Changing them after reset release has no effect on `div_clk` or `tc_pulse`.
- R8: In every mode, each falling edge of `div_clk` comes in the same cycle as a `tc_pulse`, and `div_clk` is 0 whenever `tc_pulse` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; also captures the selection inputs |
| mode_sel | input | 2 | Structure select: 00 skewed chain, 01 balanced chain, 1x reload counter |
| count_down | input | 1 | Reload counter direction: 0 up, 1 down |
| div_clk | output | 1 | Divided clock, registered |
| tc_pulse | output | 1 | One-cycle pulse at the end of each period, registered |

## Verification
The bound checker checks the mode-independent behaviour on every cycle:
- `tc_pulse` lasts one cycle and comes exactly 96 cycles apart.
- The outputs are low after reset.
- A falling output edge always coincides with the pulse.
- The captured selection holds steady outside reset.

The exact waveform shape can only be shown by the bench's scenarios, which compare every cycle against a computed model for each mode and direction. These are the 64/32 split of the skewed chain, the 48/48 split of the balanced chain, and the 32/64 split of the reload counter in both directions. The bench also changes the selection inputs while the divider is running, to show that they are ignored.

// File: rtl/div96_pkg.sv
package div96_pkg;
  typedef enum logic [1:0] {
    MODE_SKEW   = 2'b00,
    MODE_BAL    = 2'b01,
    MODE_RELOAD = 2'b10
  } div_mode_e;

  localparam int DIV_RATIO = 96;

  function automatic div_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   return MODE_SKEW;
      2'b01:   return MODE_BAL;
      default: return MODE_RELOAD;
    endcase
  endfunction
endpackage

// File: rtl/div96_modn_stage.sv
// Counter that advances on step and clears when the incremented value
// contains every set bit of MOD_N (partial-state detect, synchronous).
module div96_modn_stage #(
  parameter int MOD_N = 6,
  parameter int W     = $clog2(MOD_N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nx,
  output logic         wrap
);
  localparam logic [W-1:0] DETECT = W'(MOD_N);

  logic [W-1:0] inc;
  logic         hit;

  always_comb begin
    inc    = cnt_q + 1'b1;
    hit    = ((inc & DETECT) == DETECT);
    cnt_nx = step ? (hit ? '0 : inc) : cnt_q;
    wrap   = step & hit;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/div96_chain.sv
// Binary prescaler -> modulo-N stage, optionally followed by a toggle stage.
module div96_chain #(
  parameter int PRE_W  = 4,
  parameter int MOD_N  = 6,
  parameter bit TOGGLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output logic div_nx,
  output logic tc_nx
);
  localparam int MW = $clog2(MOD_N);

  logic [PRE_W-1:0] pre_q;
  logic             pre_full;
  logic [MW-1:0]    mod_q;
  logic [MW-1:0]    mod_nx;
  logic             mod_wrap;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign pre_full = &pre_q;

  div96_modn_stage #(.MOD_N(MOD_N), .W(MW)) u_modn (
    .clk    (clk),
    .rst    (rst),
    .step   (pre_full),
    .cnt_q  (mod_q),
    .cnt_nx (mod_nx),
    .wrap   (mod_wrap)
  );

  generate
    if (TOGGLE) begin : g_toggle
      logic tog_q;
      always_ff @(posedge clk) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= tog_q ^ mod_wrap;
      end
      assign div_nx = tog_q ^ mod_wrap;
      assign tc_nx  = mod_wrap & tog_q;
    end else begin : g_msb
      assign div_nx = mod_nx[MW-1];
      assign tc_nx  = mod_wrap;
    end
  endgenerate
endmodule

// File: rtl/div96_reload_cnt.sv
// Counter that reloads itself on end-of-count; up or down with mirrored values.
module div96_reload_cnt #(
  parameter int CNT_W    = 7,
  parameter int LOAD_VAL = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic down,
  output logic div_nx,
  output logic tc_nx
);
  localparam logic [CNT_W-1:0] UP_LOAD = CNT_W'(LOAD_VAL);
  localparam logic [CNT_W-1:0] DN_LOAD = ~UP_LOAD;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             eoc;

  always_comb begin
    eoc    = down ? (cnt_q == '0) : (&cnt_q);
    if (eoc)       cnt_nx = down ? DN_LOAD : UP_LOAD;
    else if (down) cnt_nx = cnt_q - 1'b1;
    else           cnt_nx = cnt_q + 1'b1;
    div_nx = down ? ~cnt_nx[CNT_W-1] : cnt_nx[CNT_W-1];
    tc_nx  = eoc;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= down ? DN_LOAD : UP_LOAD;
    else     cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/div96_top.sv
module div96_top
  import div96_pkg::*;
#(
  parameter int SKEW_PRE_W = 4,
  parameter int BAL_PRE_W  = 3,
  parameter int MOD_N      = 6,
  parameter int CNT_W      = 7,
  parameter int LOAD_VAL   = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       count_down,
  output logic       div_clk,
  output logic       tc_pulse
);
  div_mode_e mode_q;
  logic      down_q;
  logic      down_eff;
  logic      skew_div, skew_tc, bal_div, bal_tc, rl_div, rl_tc;
  logic      rst_skew, rst_bal, rst_rl;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= decode_mode(mode_sel);
      down_q <= count_down;
    end
  end

  assign down_eff = rst ? count_down : down_q;
  assign rst_skew = rst | (mode_q != MODE_SKEW);
  assign rst_bal  = rst | (mode_q != MODE_BAL);
  assign rst_rl   = rst | (mode_q != MODE_RELOAD);

  div96_chain #(.PRE_W(SKEW_PRE_W), .MOD_N(MOD_N), .TOGGLE(1'b0)) u_skew (
    .clk(clk), .rst(rst_skew), .div_nx(skew_div), .tc_nx(skew_tc)
  );

  div96_chain #(.PRE_W(BAL_PRE_W), .MOD_N(MOD_N), .TOGGLE(1'b1)) u_bal (
    .clk(clk), .rst(rst_bal), .div_nx(bal_div), .tc_nx(bal_tc)
  );

  div96_reload_cnt #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_reload (
    .clk(clk), .rst(rst_rl), .down(down_eff), .div_nx(rl_div), .tc_nx(rl_tc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_clk  <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      case (mode_q)
        MODE_SKEW: begin div_clk <= skew_div; tc_pulse <= skew_tc; end
        MODE_BAL:  begin div_clk <= bal_div;  tc_pulse <= bal_tc;  end
        default:   begin div_clk <= rl_div;   tc_pulse <= rl_tc;   end
      endcase
    end
  end
endmodule

// File: rtl/div96_checker.sv
module div96_checker
  import div96_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      div_clk,
  input logic      tc_pulse,
  input div_mode_e mode_q
);
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (rst)           gap <= '0;
    else if (tc_pulse) gap <= 8'd1;
    else               gap <= gap + 8'd1;
  end

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!div_clk && !tc_pulse));

  a_r2_tc_single: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  a_r2_tc_spacing: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (gap == 8'(DIV_RATIO)));

  a_r2_tc_due: assert property (@(posedge clk) disable iff (rst)
    (gap == 8'(DIV_RATIO)) |-> tc_pulse);

  a_r8_fall_with_tc: assert property (@(posedge clk) disable iff (rst)
    $fell(div_clk) |-> tc_pulse);

  a_r8_low_at_tc: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> !div_clk);

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));
endmodule

bind div96_top div96_checker u_div96_checker (
  .clk(clk), .rst(rst), .div_clk(div_clk), .tc_pulse(tc_pulse), .mode_q(mode_q)
);

// File: tb/div96_top_tb_top.sv
`timescale 1ns/1ps
module div96_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       count_down = 1'b0;
  logic       div_clk, tc_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  div96_top dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .count_down(count_down),
    .div_clk(div_clk), .tc_pulse(tc_pulse)
  );

  function automatic logic exp_div(input logic [1:0] m, input int n);
    if (m == 2'b00) return ((n / 16) % 6) >= 4;
    if (m == 2'b01) return ((n / 48) % 2) == 1;
    return (n % 96) >= 32;
  endfunction

  function automatic logic exp_tc(input int n);
    return (n > 0) && (n % 96 == 0);
  endfunction

  function automatic string mode_tag(input logic [1:0] m, input logic d);
    if (m == 2'b00) return "R3";
    if (m == 2'b01) return "R4";
    return d ? "R6" : "R5";
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic d, input int len, input bit scramble);
    logic prev_div;
    string tag;
    @(negedge clk);
    rst = 1'b1; mode_sel = m; count_down = d;
    repeat (3) @(negedge clk);
    check("R1", div_clk, 1'b0);
    check("R1", tc_pulse, 1'b0);
    rst = 1'b0;
    prev_div = 1'b0;
    tag = scramble ? "R7" : mode_tag(m, d);
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      if (n == 1) check("R1", div_clk, exp_div(m, 1));
      check(tag, div_clk, exp_div(m, n));
      check("R2", tc_pulse, exp_tc(n));
      if (prev_div && !div_clk) check("R8", tc_pulse, 1'b1);
      prev_div = div_clk;
      if (scramble && ($urandom % 8 == 0)) begin
        mode_sel = 2'($urandom);
        count_down = 1'($urandom);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // directed: each structure, both directions, alias encoding
    run(2'b00, 1'b0, 300, 1'b0);
    run(2'b01, 1'b0, 300, 1'b0);
    run(2'b10, 1'b0, 300, 1'b0);
    run(2'b10, 1'b1, 300, 1'b0);
    run(2'b11, 1'b1, 200, 1'b0);
    // R7: selection inputs change while running
    run(2'b00, 1'b1, 400, 1'b1);
    run(2'b10, 1'b1, 400, 1'b1);
    // random mix
    for (int k = 0; k < 8; k++) begin
      run(2'($urandom), 1'($urandom), 150 + int'($urandom % 300), bit'($urandom % 2));
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (R2) actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule